// File: doc/BRIEF.md
# Selectable-Preset CRC-16 Engine

This block computes a 16-bit cyclic redundancy check over a stream of bytes for the datapath of a contactless card reader. The generator is fixed at x^16 + x^12 + x^5 + 1. The CRC register is seeded from one of four constant presets. Each byte can be folded in most-significant bit first, or least-significant bit first. The LSB-first mode uses the reflected form of the same generator, which is the convention of the ITU-T and ISO/IEC 14443 type A checksums.

A controller pulses the start strobe to seed the register, then presents bytes with a valid strobe. The engine takes one bit per clock, so each byte occupies it for eight cycles. During those cycles busy is high and further bytes are not taken. When the eighth bit has been folded in, done rises. The result is read as two 8-bit halves. No final inversion and no output reflection are applied.

Top module: `crc16_engine`

## Requirements
- R1: A start pulse loads the preset picked by `preset_sel_i` into the CRC register: code 2'b00 gives 0x0000, 2'b01 gives 0x6363, 2'b10 gives 0xA671 and 2'b11 gives 0xFFFF. The value is visible on the outputs one cycle after the start cycle.
- R2: If start and a valid byte arrive in the same cycle, the start wins. The byte is dropped, busy stays low and the register holds the preset.
- R3: With `msb_first_i` = 1, bit 7 of each byte enters first and the register shifts toward bit 15 with feedback 0x1021. Preset 0xFFFF over the ASCII bytes "123456789" yields 0x29B1.
- R4: With `msb_first_i` = 0, bit 0 of each byte enters first and the register shifts toward bit 0 with the reflected feedback 0x8408. Preset 0xFFFF over "123456789" yields 0x6F91.
- R5: Preset code 2'b01 with LSB-first order over the bytes 0x00 0x00 gives a low byte of 0xA0 and a high byte of 0x1E.
- R6: A byte offered while idle and without start is accepted at that clock edge. Busy is then high for exactly 8 cycles.
- R7: While busy, `byte_valid_i` is ignored. The extra byte changes neither the result nor the busy time, and no second byte is started later.
- R8: Done rises in the cycle busy falls after the eighth bit. It is cleared by start or by accepting a new byte, and it is never high together with busy. The result has no final XOR, so preset 0x0000 over the byte 0x00 gives 0x0000.
- R9: `crc_hi_o` carries register bits 15..8 and `crc_lo_o` carries bits 7..0. The register changes only on a start or during bit processing.
- R10: Reset sets the register to 0x0000 and clears busy and done.
- R11: A start while busy aborts the byte in progress. The next cycle shows busy low, done low and the newly selected preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| start_i | input | 1 | Seed the register with the selected preset, clear done, abort a byte |
| byte_valid_i | input | 1 | Byte on `byte_i` is offered this cycle |
| byte_i | input | 8 | Data byte |
| preset_sel_i | input | 2 | Preset code, sampled with start |
| msb_first_i | input | 1 | 1: MSB first, 0: LSB first, sampled with the byte |
| crc_hi_o | output | 8 | Upper result byte |
| crc_lo_o | output | 8 | Lower result byte |
| busy_o | output | 1 | A byte is being folded in |
| done_o | output | 1 | The last accepted byte is fully folded in |

## Verification
The engine is driven with the nine-digit ASCII check string in both bit orders under preset 0xFFFF. Matching the two published residues separates the shift-left, 0x1021 path from the shift-right, 0x8408 path, and would expose a swapped or misaligned bit index. The two-zero-byte frame under preset 0x6363 pins the type A checksum. Preset 0x0000 over a zero byte shows that no output inversion is applied. Overlapping strobes cover the remaining control cases: start together with a byte, a byte offered mid-shift and a start mid-shift, which together separate the priority, the ignore rule and the abort path. A per-clock reference model checks the state of busy, done and the register throughout.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int CRC_W    = 16;
  localparam int DATA_W   = 8;
  localparam int PRESET_N = 4;
  localparam int SEL_W    = $clog2(PRESET_N);
  localparam logic [CRC_W-1:0] POLY = 16'h1021;

  typedef logic [CRC_W-1:0] crc_t;
  typedef enum logic [0:0] {ST_IDLE, ST_SHIFT} ctrl_state_e;

  function automatic crc_t preset_value(input logic [SEL_W-1:0] code);
    crc_t v;
    case (code)
      2'd0:    v = 16'h0000;
      2'd1:    v = 16'h6363;
      2'd2:    v = 16'hA671;
      default: v = 16'hFFFF;
    endcase
    return v;
  endfunction

  function automatic crc_t mirror(input crc_t v);
    crc_t r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/crc16_preset_sel.sv
module crc16_preset_sel
  import crc16_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int W  = CRC_W
) (
  input  logic [SW-1:0] sel_i,
  output logic [W-1:0]  preset_o
);
  localparam int N = 1 << SW;
  logic [N-1:0][W-1:0] table_w;
  logic [N-1:0]        hit_w;

  for (genvar g = 0; g < N; g++) begin : g_entry
    assign table_w[g] = W'(preset_value(SEL_W'(g)));
    assign hit_w[g]   = (sel_i == SW'(g));
  end

  always_comb begin
    preset_o = '0;
    for (int i = 0; i < N; i++)
      if (hit_w[i]) preset_o = preset_o | table_w[i];
  end
endmodule

// File: rtl/crc16_bit_step.sv
module crc16_bit_step
  import crc16_pkg::*;
#(
  parameter int                W = CRC_W,
  parameter logic [CRC_W-1:0]  P = POLY
) (
  input  logic [W-1:0] crc_i,
  input  logic         bit_i,
  input  logic         msb_first_i,
  output logic [W-1:0] crc_o
);
  localparam logic [W-1:0] P_FWD = P[W-1:0];
  localparam logic [W-1:0] P_REV = W'(mirror(P));

  logic         fb_fwd, fb_rev;
  logic [W-1:0] nxt_fwd, nxt_rev;

  always_comb begin
    fb_fwd  = crc_i[W-1] ^ bit_i;
    nxt_fwd = {crc_i[W-2:0], 1'b0} ^ (fb_fwd ? P_FWD : '0);
    fb_rev  = crc_i[0] ^ bit_i;
    nxt_rev = {1'b0, crc_i[W-1:1]} ^ (fb_rev ? P_REV : '0);
    crc_o   = msb_first_i ? nxt_fwd : nxt_rev;
  end
endmodule

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          msb_first_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          bit_o,
  output logic          order_o,
  output logic          step_o,
  output logic          load_o
);
  localparam int            CNT_W = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

  ctrl_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0]    sh_q, sh_d;
  logic             ord_q, ord_d;
  logic             done_q, done_d;
  logic             accept, en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ord_d   = ord_q;
    done_d  = done_q;
    accept  = 1'b0;
    if (start_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      done_d  = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (valid_i) begin
          accept  = 1'b1;
          sh_d    = data_i;
          ord_d   = msb_first_i;
          cnt_d   = '0;
          done_d  = 1'b0;
          state_d = ST_SHIFT;
        end
        default: begin
          sh_d = ord_q ? {sh_q[DW-2:0], 1'b0} : {1'b0, sh_q[DW-1:1]};
          if (cnt_q == LAST) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign en = start_i | accept | (state_q == ST_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ord_q   <= 1'b0;
      done_q  <= 1'b0;
    end else if (en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ord_q   <= ord_d;
      done_q  <= done_d;
    end
  end

  assign busy_o  = (state_q == ST_SHIFT);
  assign done_o  = done_q;
  assign bit_o   = ord_q ? sh_q[DW-1] : sh_q[0];
  assign order_o = ord_q;
  assign step_o  = busy_o & ~start_i;
  assign load_o  = start_i;

  assert_start_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!busy_o && !done_o));
  assert_accept_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && valid_i && !busy_o) |=> busy_o);
  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i && valid_i && cnt_q != LAST) |=> (busy_o && cnt_q == $past(cnt_q) + CNT_W'(1)));
  assert_done_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i && cnt_q == LAST) |=> (done_o && !busy_o));
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc16_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int W  = CRC_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          byte_valid_i,
  input  logic [DW-1:0] byte_i,
  input  logic [SW-1:0] preset_sel_i,
  input  logic          msb_first_i,
  output logic [W/2-1:0] crc_hi_o,
  output logic [W/2-1:0] crc_lo_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int HALF = W / 2;

  logic [W-1:0] crc_q, crc_d, preset_w, stepped_w;
  logic         bit_w, order_w, step_w, load_w, crc_en;

  crc16_ctrl #(.DW(DW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(byte_valid_i),
    .data_i(byte_i), .msb_first_i(msb_first_i), .busy_o(busy_o),
    .done_o(done_o), .bit_o(bit_w), .order_o(order_w), .step_o(step_w),
    .load_o(load_w)
  );

  crc16_preset_sel #(.SW(SW), .W(W)) preset_i (
    .sel_i(preset_sel_i), .preset_o(preset_w)
  );

  crc16_bit_step #(.W(W)) step_i (
    .crc_i(crc_q), .bit_i(bit_w), .msb_first_i(order_w), .crc_o(stepped_w)
  );

  always_comb begin
    crc_en = load_w | step_w;
    crc_d  = load_w ? preset_w : stepped_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_hi_o = crc_q[W-1:HALF];
  assign crc_lo_o = crc_q[HALF-1:0];

  assert_preset_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && preset_sel_i == SW'(1)) |=> ({crc_hi_o, crc_lo_o} == 16'h6363));
  assert_preset_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && preset_sel_i == SW'(2)) |=> ({crc_hi_o, crc_lo_o} == 16'hA671));
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(crc_q));
  assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o);
  assert_reset_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (crc_q == '0 && !busy_o && !done_o));
endmodule

// File: tb/crc16_engine_tb_top.sv
`timescale 1ns/1ps
module crc16_engine_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, start, valid, msb;
  logic [7:0] data;
  logic [1:0] sel;
  logic [7:0] hi, lo;
  logic       busy, done;
  int n_run = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  crc16_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .byte_valid_i(valid),
    .byte_i(data), .preset_sel_i(sel), .msb_first_i(msb),
    .crc_hi_o(hi), .crc_lo_o(lo), .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int preset_of(input int code);
    case (code)
      0: return 'h0000; 1: return 'h6363; 2: return 'hA671; default: return 'hFFFF;
    endcase
  endfunction

  // byte-wise software model
  function automatic int sw_crc(input byte unsigned q[$], input int init, input bit m);
    int c = init;
    foreach (q[k]) begin
      if (m) c = c ^ (int'(q[k]) << 8); else c = c ^ int'(q[k]);
      for (int j = 0; j < 8; j++) begin
        if (m) c = (c & 'h8000) ? (((c << 1) ^ 'h1021) & 'hFFFF) : ((c << 1) & 'hFFFF);
        else   c = (c & 1) ? ((c >> 1) ^ 'h8408) : (c >> 1);
      end
    end
    return c;
  endfunction

  // cycle reference model
  int m_crc, m_byte, m_cnt;
  bit m_busy, m_done, m_ord;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_crc = 0; m_busy = 0; m_done = 0; m_cnt = 0; m_byte = 0; m_ord = 0;
    end else if (start) begin
      m_crc = preset_of(int'(sel)); m_busy = 0; m_done = 0;
    end else if (m_busy) begin
      bit b, fb;
      b = m_ord ? m_byte[7 - m_cnt] : m_byte[m_cnt];
      if (m_ord) begin
        fb = m_crc[15] ^ b;
        m_crc = ((m_crc << 1) & 'hFFFF) ^ (fb ? 'h1021 : 0);
      end else begin
        fb = m_crc[0] ^ b;
        m_crc = (m_crc >> 1) ^ (fb ? 'h8408 : 0);
      end
      m_cnt++;
      if (m_cnt == 8) begin m_busy = 0; m_done = 1; end
    end else if (valid) begin
      m_byte = int'(data); m_ord = msb; m_cnt = 0; m_busy = 1; m_done = 0;
    end
  end

  always @(negedge clk)
    if (rst_n && cmp_on)
      check(busy == m_busy && done == m_done && {hi, lo} == m_crc[15:0],
            "R6/R8/R9 per-cycle model", int'({busy, done, hi, lo}),
            int'({m_busy, m_done, m_crc[15:0]}));

  task automatic do_start(input int code);
    @(negedge clk); start = 1; sel = 2'(code);
    @(negedge clk); start = 0;
  endtask

  task automatic send(input byte unsigned b, input bit m);
    @(negedge clk);
    while (busy) @(negedge clk);
    valid = 1; data = b; msb = m;
    @(negedge clk); valid = 0;
    repeat (7) @(negedge clk);
  endtask

  task automatic run(input int code, input bit m, input byte unsigned q[$], output int res);
    do_start(code);
    foreach (q[k]) send(q[k], m);
    @(negedge clk);
    res = int'({hi, lo});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog R6 actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    byte unsigned digits[$] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    byte unsigned zz[$] = '{8'h00, 8'h00};
    byte unsigned one[$] = '{8'h5A};
    int r, cyc;
    rst_n = 0; start = 0; valid = 0; data = 0; sel = 0; msb = 0;
    repeat (3) @(negedge clk);
    check({hi, lo, busy, done} == 0, "R10 reset outputs", int'({hi, lo, busy, done}), 0);
    rst_n = 1;
    @(negedge clk);
    check({hi, lo, busy, done} == 0, "R10 after release", int'({hi, lo, busy, done}), 0);
    cmp_on = 1;

    for (int c = 0; c < 4; c++) begin
      do_start(c);
      check({hi, lo} == preset_of(c), "R1 preset load", int'({hi, lo}), preset_of(c));
    end

    run(3, 1'b1, digits, r);
    check(r == 'h29B1, "R3 MSB-first check string", r, 'h29B1);
    check(r == sw_crc(digits, 'hFFFF, 1'b1), "R3 vs software model", r, sw_crc(digits, 'hFFFF, 1'b1));
    check(done && !busy, "R8 done after last byte", int'({done, busy}), 2);

    run(3, 1'b0, digits, r);
    check(r == 'h6F91, "R4 LSB-first check string", r, 'h6F91);

    run(1, 1'b0, zz, r);
    check(lo == 8'hA0 && hi == 8'h1E, "R5 type A zero frame", r, 'h1EA0);
    check(r == sw_crc(zz, 'h6363, 1'b0), "R5 vs software model", r, sw_crc(zz, 'h6363, 1'b0));
    check(hi == r[15:8] && lo == r[7:0], "R9 byte halves", int'({hi, lo}), r);

    run(2, 1'b1, one, r);
    check(r == sw_crc(one, 'hA671, 1'b1), "R3 preset A671 MSB", r, sw_crc(one, 'hA671, 1'b1));

    // R8: no final XOR, done cleared by start
    run(0, 1'b1, '{8'h00}, r);
    check(r == 0, "R8 no final xor", r, 0);
    do_start(0);
    check(!done, "R8 start clears done", int'(done), 0);

    // R6: busy length
    @(negedge clk); valid = 1; data = 8'hC3; msb = 0;
    @(negedge clk); valid = 0;
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    check(cyc == 8, "R6 busy cycles", cyc, 8);
    check(done, "R8 done at busy fall", int'(done), 1);

    // R7: byte offered while busy is ignored
    do_start(0);
    @(negedge clk); valid = 1; data = 8'h5A; msb = 0;
    @(negedge clk); valid = 0;
    @(negedge clk); valid = 1; data = 8'hFF;
    @(negedge clk); valid = 0;
    repeat (6) @(negedge clk);
    check(done && !busy, "R7 busy length unchanged", int'({done, busy}), 2);
    check({hi, lo} == sw_crc(one, 0, 1'b0), "R7 result unaffected", int'({hi, lo}), sw_crc(one, 0, 1'b0));
    @(negedge clk);
    check(!busy && {hi, lo} == sw_crc(one, 0, 1'b0), "R7 no late accept", int'({busy, hi, lo}), sw_crc(one, 0, 1'b0));

    // R2: start beats byte
    @(negedge clk); start = 1; sel = 2'd3; valid = 1; data = 8'hAA; msb = 1;
    @(negedge clk); start = 0; valid = 0;
    check(!busy && {hi, lo} == 16'hFFFF, "R2 start wins", int'({busy, hi, lo}), 'hFFFF);
    @(negedge clk);
    check(!busy && {hi, lo} == 16'hFFFF, "R2 byte dropped", int'({busy, hi, lo}), 'hFFFF);

    // R11: start aborts a byte in progress
    @(negedge clk); valid = 1; data = 8'h77; msb = 1;
    @(negedge clk); valid = 0;
    repeat (2) @(negedge clk);
    start = 1; sel = 2'd2;
    @(negedge clk); start = 0;
    check(!busy && !done && {hi, lo} == 16'hA671, "R11 abort on start", int'({busy, done, hi, lo}), 'hA671);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule